// File: doc/BRIEF.md
# Register Stack With Flags

A last-in-first-out store of 64 words held in registers, with a 6-bit stack pointer and two flags marking a full and an empty stack. A push advances the pointer first and then writes the incoming word at the new position. A pop reads the word at the current position and then steps the pointer back. A single data register holds either the word just pushed or the word just popped, and keeps that value while the stack is idle.

The pointer counts modulo 64. Because of this, the pointer reads 0 both when the stack is empty and when it holds all 64 words. Only the flags tell these two states apart. The first word goes to location 1 and the 64th word goes to location 0. A push into a full stack, or a pop from an empty one, is refused and reported by a one-cycle pulse. A cycle that requests both a push and a pop does nothing.

Top module: `regstack_lifo`

## Requirements
- R1: After reset, `sp_o` is 0, `empty_o` is 1, `full_o` is 0, `dr_o` is 0, and `ovf_o` and `unf_o` are 0.
- R2: An accepted push (push_i=1, pop_i=0, full_o=0) sets `sp_o` to (sp_o+1) mod 64 and loads `push_data_i` into `dr_o`, both visible after the same clock edge.
- R3: After an accepted push, `empty_o` is 0, and `full_o` is 1 exactly when the new `sp_o` is 0.
- R4: An accepted pop (pop_i=1, push_i=0, empty_o=0) loads into `dr_o` the most recently pushed word that has not yet been popped, and sets `sp_o` to (sp_o−1) mod 64.
- R5: After an accepted pop, `full_o` is 0, and `empty_o` is 1 exactly when the new `sp_o` is 0.
- R6: A push request while `full_o` is 1 leaves `sp_o`, `dr_o`, the flags and the stored words unchanged, and raises `ovf_o` for the one cycle after that edge.
- R7: A pop request while `empty_o` is 1 leaves `sp_o`, `dr_o` and the flags unchanged, and raises `unf_o` for the one cycle after that edge.
- R8: A cycle with both push_i and pop_i at 1 changes nothing, and neither `ovf_o` nor `unf_o` rises.
- R9: In a cycle with neither request, `dr_o`, `sp_o` and the flags hold their values.
- R10: `full_o` and `empty_o` are never 1 at the same time.
- R11: Exactly 64 pushes are accepted from the empty state. After the 64th push, `sp_o` reads 0 with `full_o` at 1, and a following pop returns the 64th word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| push_data_i | input | DATA_W (16) | Word to push |
| dr_o | output | DATA_W (16) | Data register: last pushed or popped word |
| sp_o | output | ADDR_W (6) | Stack pointer |
| full_o | output | 1 | Stack holds 64 words |
| empty_o | output | 1 | Stack holds no words |
| ovf_o | output | 1 | One-cycle pulse: a push was refused |
| unf_o | output | 1 | One-cycle pulse: a pop was refused |

## Verification
A wrong pointer step shows on `sp_o` in the cycle right after the edge that caused it. A wrong write or read address stays hidden until the affected word is popped, and that can be many cycles later. A flag that wraps early or late shows up first as a refused operation, or a missing refusal, at the 64-word boundary. It then shows as a wrong popped value or a wrong pointer. So the stimulus keeps driving the stack through repeated fill and drain runs that cross both boundaries, and compares every popped word against a model of the stack contents.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  // Pointer arithmetic kept in one place. Plain integers, modulo the depth.
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input logic [31:0] depth);
    return (v + 32'd1 >= depth) ? 32'd0 : v + 32'd1;
  endfunction

  function automatic logic [31:0] wrap_dec(input logic [31:0] v, input logic [31:0] depth);
    return (v == 32'd0) ? depth - 32'd1 : v - 32'd1;
  endfunction

endpackage

// File: rtl/lrs_ctrl.sv
module lrs_ctrl (
  input  logic push_req,
  input  logic pop_req,
  input  logic full,
  input  logic empty,
  output logic push_ok,
  output logic pop_ok,
  output logic ovf_evt,
  output logic unf_evt
);
  logic solo_push;
  logic solo_pop;

  // Both requests together cancel each other (R8).
  assign solo_push = push_req & ~pop_req;
  assign solo_pop  = pop_req & ~push_req;

  always_comb begin
    push_ok = solo_push & ~full;
    pop_ok  = solo_pop & ~empty;
    ovf_evt = solo_push & full;
    unf_evt = solo_pop & empty;
  end
endmodule

// File: rtl/lrs_ptr.sv
module lrs_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_ok,
  input  logic              pop_ok,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] sp_up,
  output logic              full,
  output logic              empty
);
  import lrs_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] sp_dn;

  assign sp_up = ADDR_W'(wrap_inc(32'(sp), 32'(DEPTH)));
  assign sp_dn = ADDR_W'(wrap_dec(32'(sp), 32'(DEPTH)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else if (push_ok) begin
      sp    <= sp_up;
      full  <= (sp_up == '0);
      empty <= 1'b0;
    end else if (pop_ok) begin
      sp    <= sp_dn;
      full  <= 1'b0;
      empty <= (sp_dn == '0);
    end
  end

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> sp == ADDR_W'($past(sp) + 1'b1));
  assert_push_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> !empty && (full == (sp == '0)));
  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> sp == ADDR_W'($past(sp) - 1'b1));
  assert_pop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> !full && (empty == (sp == '0)));
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ok && !pop_ok) |=> $stable(sp) && $stable(full) && $stable(empty));
endmodule

// File: rtl/lrs_store.sv
module lrs_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/regstack_lifo.sv
module regstack_lifo #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] dr_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic              push_ok, pop_ok, ovf_evt, unf_evt;
  logic [ADDR_W-1:0] sp_up;
  logic [DATA_W-1:0] rd_word;

  lrs_ctrl u_ctrl (
    .push_req (push_i),
    .pop_req  (pop_i),
    .full     (full_o),
    .empty    (empty_o),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .ovf_evt  (ovf_evt),
    .unf_evt  (unf_evt)
  );

  lrs_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .sp      (sp_o),
    .sp_up   (sp_up),
    .full    (full_o),
    .empty   (empty_o)
  );

  // Writes go to the pointer's next position; reads come from the current one.
  lrs_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (push_ok),
    .waddr (sp_up),
    .wdata (push_data_i),
    .raddr (sp_o),
    .rdata (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_o  <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= ovf_evt;
      unf_o <= unf_evt;
      if (push_ok)     dr_o <= push_data_i;
      else if (pop_ok) dr_o <= rd_word;
    end
  end

  assert_push_dr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> dr_o == $past(push_data_i));
  assert_pop_dr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> dr_o == $past(rd_word));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> ovf_o && $stable(sp_o) && $stable(dr_o) && full_o);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> unf_o && $stable(sp_o) && $stable(dr_o) && empty_o);
  assert_clash_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> !ovf_o && !unf_o && $stable(sp_o) && $stable(dr_o));
  assert_dr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(dr_o) && !ovf_o && !unf_o);
endmodule

// File: tb/sim_regstack_lifo.sv
`timescale 1ns/1ps
module sim_regstack_lifo;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [DW-1:0] push_data_i = '0;
  logic [DW-1:0] dr_o;
  logic [AW-1:0] sp_o;
  logic          full_o, empty_o, ovf_o, unf_o;

  regstack_lifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .dr_o(dr_o), .sp_o(sp_o),
    .full_o(full_o), .empty_o(empty_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  always #5 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // Reference model
  int unsigned m_mem [DEPTH];
  int unsigned m_sp, m_dr;
  bit m_full, m_empty, m_ovf, m_unf;

  function automatic int unsigned up1(int unsigned s);
    return (s + 1) % DEPTH;
  endfunction
  function automatic int unsigned dn1(int unsigned s);
    return (s + DEPTH - 1) % DEPTH;
  endfunction

  task automatic chk(input string tag, input string what, input int unsigned act, input int unsigned exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit p, input bit q, input int unsigned d);
    string t;
    @(negedge clk);
    push_i = p; pop_i = q; push_data_i = DW'(d);
    m_ovf = 0; m_unf = 0;
    if (p && !q && !m_full) begin
      m_sp = up1(m_sp); m_mem[m_sp] = d % 65536; m_dr = d % 65536;
      m_empty = 0; m_full = (m_sp == 0); t = "R2/R3";
    end else if (q && !p && !m_empty) begin
      m_dr = m_mem[m_sp]; m_sp = dn1(m_sp);
      m_full = 0; m_empty = (m_sp == 0); t = "R4/R5";
    end else if (p && !q) begin
      m_ovf = 1; t = "R6";
    end else if (q && !p) begin
      m_unf = 1; t = "R7";
    end else if (p && q) t = "R8";
    else t = "R9";
    @(posedge clk); #1;
    chk(t, "sp", 32'(sp_o), m_sp);
    chk(t, "dr", 32'(dr_o), m_dr);
    chk(t, "full", 32'(full_o), 32'(m_full));
    chk(t, "empty", 32'(empty_o), 32'(m_empty));
    chk(t, "ovf", 32'(ovf_o), 32'(m_ovf));
    chk(t, "unf", 32'(unf_o), 32'(m_unf));
    chk("R10", "flags", 32'(full_o & empty_o), 0);
  endtask

  initial begin
    int unsigned r;
    bit fill_bias;
    void'($urandom(32'd20240611));
    m_sp = 0; m_dr = 0; m_full = 0; m_empty = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "sp", 32'(sp_o), 0);
    chk("R1", "empty", 32'(empty_o), 1);
    chk("R1", "full", 32'(full_o), 0);
    chk("R1", "dr", 32'(dr_o), 0);
    chk("R1", "pulses", 32'({ovf_o, unf_o}), 0);
    @(negedge clk); rst_n = 1'b1;

    step(0, 1, 0);          // R7 pop on empty
    step(0, 0, 0);          // R9 pulse gone
    step(1, 1, 16'h1111);   // R8 clash on empty
    step(1, 0, 16'hA5A5);   // R2 first push
    step(1, 0, 16'h5A5A);
    step(0, 0, 0);          // R9
    step(1, 1, 16'hFFFF);   // R8 clash with content
    step(0, 1, 0);          // R4
    step(0, 1, 0);          // R5 back to empty
    step(0, 1, 0);          // R7

    // R11 fill exactly 64, overflow on 65th, then drain
    for (int i = 0; i < DEPTH; i++) step(1, 0, 32'h100 + i);
    chk("R11", "sp after 64", 32'(sp_o), 0);
    chk("R11", "full after 64", 32'(full_o), 1);
    step(1, 0, 16'hDEAD);   // R6 refused push
    step(1, 0, 16'hBEEF);   // R6 again
    step(1, 1, 16'h0);      // R8 on full
    step(0, 1, 0);          // R11 first pop returns 64th word
    chk("R11", "first pop word", 32'(dr_o), 32'h100 + 63);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 1, 0);
    chk("R5", "empty after drain", 32'(empty_o), 1);

    // Random phases alternating between fill- and drain-biased traffic
    fill_bias = 1;
    for (int i = 0; i < 4000; i++) begin
      if (i % 150 == 0) fill_bias = ~fill_bias;
      r = $urandom % 16;
      if (r < 1)       step(1, 1, $urandom);
      else if (r < 3)  step(0, 0, 0);
      else if (r < 11) step(fill_bias, !fill_bias, $urandom);
      else             step(!fill_bias, fill_bias, $urandom);
    end
    finished = 1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule